// File: doc/BRIEF.md
# Serial Line Byte Receiver with Unstuffing and CRC-4

This block turns a single NRZI-coded serial line into bytes. The line has already been sampled once per bit period. A one-cycle strobe, `bitEn`, marks each sample. The receiver first decodes the NRZI levels into logical bits. It then deletes the zero bits that a transmitter inserts after five ones, and watches for the zero that opens a frame.

Each frame holds 12 bits after its start bit: eight data bits, then a four-bit check word over them. When the last bit has arrived, the byte is presented for one clock cycle. A flag comes with it that says whether the check word matched the one recomputed over the data.

The unstuffing counter runs on every strobe, whether or not a frame is open, so stuffing carries over frame edges. A run of six ones inside a frame is a line fault: the frame is dropped and an error pulse is raised. The block is meant to sit behind a clock/data recovery stage and in front of a packet assembler.

Top module: `srx_frame_receiver`

## Requirements
- R1: On a strobe, a line level equal to the previous sampled level decodes as logical 1, and a change of level decodes as logical 0. After reset the reference level is 1.
- R2: A logical 0 that directly follows five consecutive logical 1s is a stuffed bit and is dropped. The run counter counts on every strobe, inside and outside frames, so stuffing applies across frame boundaries.
- R3: While no frame is open, the first non-stuffed logical 0 opens a frame. That start bit is not part of the data.
- R4: The 12 bits after the start bit are eight data bits, least significant first, then four check bits, most significant first. `byteValid` is high for exactly the one cycle after the clock edge that accepts the twelfth bit, and `byteData` then carries the data byte.
- R5: The check word is the CRC with generator x^4+x+1, starting from zero, over the eight data bits in line order. `crcErr` is high together with `byteValid` when the received word differs, and is low whenever `byteValid` is low.
- R6: A sixth consecutive logical 1 inside an open frame gives a one-cycle `stuffErr` pulse on the following cycle. The frame is dropped without `byteValid`, and the block returns to idle. Runs of ones while idle raise no error.
- R7: In cycles where `bitEn` is low, the line is ignored. No output pulses, and the decode state does not change.
- R8: A synchronous reset returns the block to idle, clears the run counter, sets the reference level to 1, and drives all outputs low.
- R9: `byteData` holds its last value between bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | One-cycle strobe marking a sampled bit period |
| lineIn | input | 1 | Sampled NRZI line level |
| byteValid | output | 1 | One-cycle pulse: a received byte is presented |
| byteData | output | 8 | Received data byte |
| crcErr | output | 1 | Check word mismatch, qualified by byteValid |
| stuffErr | output | 1 | One-cycle pulse: six ones inside a frame |

## Verification
Some properties are checked by assertions on every cycle:
- output pulses last one cycle;
- the byte and error pulses never coincide;
- any pulse follows a strobe;
- `crcErr` stays low outside `byteValid`;
- the byte holds between pulses.

Other properties only the bench scenarios can show. These are the decoded values, stuffing carried over back-to-back frames, aborts on six ones, silence while idle on long runs of ones, line toggles without a strobe, and reset in the middle of a frame. The bench shows them by comparing against its own bit-level model on every clock.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic clear;      // start of frame: clear accumulators
    logic shiftData;  // accepted bit is a data bit
    logic shiftCrc;   // accepted bit is a check bit
    logic emit;       // last bit of frame: present byte
    logic abort;      // six ones inside frame
  } srx_ctl_t;
endpackage

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 4'b0011,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              lineIn,
  input  srx_ctl_t          ctl,
  output logic              bitStrobe,
  output logic              bitVal,
  output logic              runFull,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData,
  output logic              crcErr,
  output logic              stuffErr
);
  localparam int RUN_W = $clog2(STUFF_RUN + 2);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(STUFF_RUN + 1);

  logic             prevLevel;
  logic [RUN_W-1:0] runCnt;
  logic [DATA_W-1:0] dataSh;
  logic [CRC_W-1:0] crcCalc;
  logic [CRC_W-1:0] crcRx;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] crcRxNext;
  logic             rawBit;
  logic             atLimit;
  logic             feedback;

  // NRZI: no change of level is a one
  assign rawBit    = (lineIn == prevLevel);
  assign atLimit   = (runCnt == RUN_LIMIT);
  assign bitVal    = rawBit;
  assign bitStrobe = bitEn && !(atLimit && !rawBit);
  assign runFull   = bitEn && rawBit && atLimit;

  assign feedback  = crcCalc[CRC_W-1] ^ bitVal;
  assign crcNext   = {crcCalc[CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
  assign crcRxNext = {crcRx[CRC_W-2:0], bitVal};

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLevel <= 1'b1;
      runCnt    <= '0;
    end else if (bitEn) begin
      prevLevel <= lineIn;
      if (rawBit) begin
        if (runCnt != RUN_SAT) runCnt <= runCnt + 1'b1;
      end else begin
        runCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataSh    <= '0;
      crcCalc   <= '0;
      crcRx     <= '0;
      byteData  <= '0;
      byteValid <= 1'b0;
      crcErr    <= 1'b0;
      stuffErr  <= 1'b0;
    end else begin
      byteValid <= ctl.emit;
      stuffErr  <= ctl.abort;
      crcErr    <= ctl.emit && (crcRxNext != crcCalc);
      if (ctl.clear) begin
        crcCalc <= '0;
        crcRx   <= '0;
      end
      if (ctl.shiftData) begin
        dataSh  <= {bitVal, dataSh[DATA_W-1:1]};
        crcCalc <= crcNext;
      end
      if (ctl.shiftCrc) crcRx <= crcRxNext;
      if (ctl.emit) byteData <= dataSh;
    end
  end
endmodule

// File: rtl/srx_control.sv
module srx_control
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitStrobe,
  input  logic     bitVal,
  input  logic     runFull,
  output srx_ctl_t ctl
);
  localparam int FRAME_LEN = DATA_W + CRC_W;
  localparam int CNT_W = $clog2(FRAME_LEN);

  typedef enum logic {IDLE, COLLECT} state_t;

  state_t           state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextCnt   = bitCnt;
    case (state)
      IDLE: begin
        if (bitStrobe && !bitVal) begin
          ctl.clear = 1'b1;
          nextState = COLLECT;
          nextCnt   = '0;
        end
      end
      default: begin
        if (runFull) begin
          ctl.abort = 1'b1;
          nextState = IDLE;
        end else if (bitStrobe) begin
          if (bitCnt < CNT_W'(DATA_W)) ctl.shiftData = 1'b1;
          else ctl.shiftCrc = 1'b1;
          if (bitCnt == CNT_W'(FRAME_LEN - 1)) begin
            ctl.emit  = 1'b1;
            nextState = IDLE;
          end
          nextCnt = bitCnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end
endmodule

// File: rtl/srx_frame_receiver.sv
module srx_frame_receiver
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W = 4,
  parameter logic [CRC_W-1:0] CRC_POLY = 4'b0011,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              lineIn,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData,
  output logic              crcErr,
  output logic              stuffErr
);
  srx_ctl_t ctl;
  logic     bitStrobe;
  logic     bitVal;
  logic     runFull;

  srx_control #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_ctrl (
    .clk(clk), .rst(rst), .bitStrobe(bitStrobe), .bitVal(bitVal),
    .runFull(runFull), .ctl(ctl)
  );

  srx_datapath #(
    .DATA_W(DATA_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .STUFF_RUN(STUFF_RUN)
  ) u_dp (
    .clk(clk), .rst(rst), .bitEn(bitEn), .lineIn(lineIn), .ctl(ctl),
    .bitStrobe(bitStrobe), .bitVal(bitVal), .runFull(runFull),
    .byteValid(byteValid), .byteData(byteData), .crcErr(crcErr),
    .stuffErr(stuffErr)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bitEn,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteData,
  input logic              crcErr,
  input logic              stuffErr
);
  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    byteValid |=> !byteValid);

  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    stuffErr |=> !stuffErr);

  a_r6_err_excl: assert property (@(posedge clk) disable iff (rst)
    byteValid |-> !stuffErr);

  a_r7_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (byteValid || stuffErr) |-> $past(bitEn));

  a_r5_crc_qualified: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> !crcErr);

  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> $stable(byteData));
endmodule

bind srx_frame_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bitEn(bitEn), .byteValid(byteValid),
  .byteData(byteData), .crcErr(crcErr), .stuffErr(stuffErr)
);

// File: tb/srx_frame_receiver_bench.sv
module srx_frame_receiver_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitEn = 1'b0;
  logic lineIn = 1'b1;
  logic byteValid;
  logic [7:0] byteData;
  logic crcErr;
  logic stuffErr;

  always #10 clk = ~clk;  // 50 MHz

  srx_frame_receiver u_srx_frame_receiver (
    .clk(clk), .rst(rst), .bitEn(bitEn), .lineIn(lineIn),
    .byteValid(byteValid), .byteData(byteData), .crcErr(crcErr),
    .stuffErr(stuffErr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [3:0] crc4(logic [7:0] d);
    logic [3:0] c = 4'h0;
    for (int i = 0; i < 8; i++) begin
      logic fb = c[3] ^ d[i];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'b0011;
    end
    return c;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic mPrev;
  int   mOnes;
  bit   mInFrame;
  bit   mQ[$];
  logic mValid, mCrc, mStuff;
  logic [7:0] mData;

  always @(posedge clk) begin
    if (rst) begin
      mPrev = 1'b1; mOnes = 0; mInFrame = 0; mQ.delete();
      mValid = 0; mCrc = 0; mStuff = 0; mData = 8'h00;
    end else begin
      mValid = 0; mCrc = 0; mStuff = 0;
      if (bitEn) begin
        bit b;
        bit keep;
        b = (lineIn == mPrev);
        mPrev = lineIn;
        keep = 1;
        if (b) begin
          if (mOnes == 5 && mInFrame) begin
            mStuff = 1; mInFrame = 0; keep = 0;
          end
          if (mOnes < 6) mOnes++;
        end else begin
          if (mOnes == 5) keep = 0;
          mOnes = 0;
        end
        if (keep) begin
          if (!mInFrame) begin
            if (!b) begin mInFrame = 1; mQ.delete(); end
          end else begin
            mQ.push_back(b);
            if (mQ.size() == 12) begin
              logic [7:0] d;
              logic [3:0] r;
              for (int i = 0; i < 8; i++) d[i] = mQ[i];
              for (int i = 0; i < 4; i++) r[3-i] = mQ[8+i];
              mValid = 1; mData = d; mCrc = (r != crc4(d));
              mInFrame = 0;
            end
          end
        end
      end
    end
  end

  // observed event counters and per-cycle comparison
  int obsValid = 0, obsCrc = 0, obsStuff = 0;
  logic [7:0] lastData = 8'h00;

  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        check("R8", "reset outputs", {byteValid, crcErr, stuffErr}, 0);
      end else begin
        check("R4", "byteValid", byteValid, mValid);
        check("R9", "byteData", byteData, mData);
        check("R5", "crcErr", crcErr, mCrc);
        check("R6", "stuffErr", stuffErr, mStuff);
        if (byteValid) begin
          obsValid++; lastData = byteData;
          if (crcErr) obsCrc++;
        end
        if (stuffErr) obsStuff++;
      end
    end
  end

  // ---------------- transmitter side ----------------
  logic txLevel = 1'b1;
  int   txOnes = 0;

  task automatic sendLine(logic b);
    if (!b) txLevel = ~txLevel;
    @(negedge clk); lineIn = txLevel; bitEn = 1'b1;
    @(negedge clk); bitEn = 1'b0;
  endtask

  task automatic sendLogical(logic b, bit stuff);
    sendLine(b);
    if (b) begin if (txOnes < 6) txOnes++; end else txOnes = 0;
    if (stuff && b && txOnes == 5) begin
      sendLine(1'b0);
      txOnes = 0;
    end
  endtask

  task automatic sendIdle(int n);
    for (int i = 0; i < n; i++) sendLogical(1'b1, 0);
  endtask

  task automatic sendFrame(logic [7:0] d, logic [3:0] crcFlip);
    logic [3:0] c;
    c = crc4(d) ^ crcFlip;
    sendLogical(1'b0, 1);
    for (int i = 0; i < 8; i++) sendLogical(d[i], 1);
    for (int i = 3; i >= 0; i--) sendLogical(c[i], 1);
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog expired got=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v0, c0, s0;
    waitCycles(3);
    rst = 1'b0;

    // R1 R3 R4: plain frame after idle
    sendIdle(8);
    v0 = obsValid;
    sendFrame(8'hA5, 4'h0);
    waitCycles(2);
    check("R4", "frame count A5", obsValid - v0, 1);
    check("R1", "data A5", lastData, 8'hA5);

    // R2: all-ones byte with stuffing, then back-to-back frame
    v0 = obsValid; c0 = obsCrc; s0 = obsStuff;
    sendFrame(8'hFF, 4'h0);
    sendFrame(8'h3E, 4'h0);
    waitCycles(2);
    check("R2", "back-to-back count", obsValid - v0, 2);
    check("R2", "data after FF", lastData, 8'h3E);
    check("R2", "no crc errors", obsCrc - c0, 0);
    check("R2", "no stuff errors", obsStuff - s0, 0);
    sendIdle(8);

    // R5: corrupted check word
    v0 = obsValid; c0 = obsCrc;
    sendFrame(8'h5C, 4'h6);
    waitCycles(2);
    check("R5", "crc error count", obsCrc - c0, 1);
    check("R5", "data still shown", lastData, 8'h5C);
    sendIdle(8);

    // R6: six ones inside a frame abort it
    v0 = obsValid; s0 = obsStuff;
    sendLogical(1'b0, 0);
    for (int i = 0; i < 7; i++) sendLogical(1'b1, 0);
    sendIdle(12);
    check("R6", "abort pulse", obsStuff - s0, 1);
    check("R6", "no byte on abort", obsValid - v0, 0);

    // R6: long idle ones raise nothing
    s0 = obsStuff;
    sendIdle(30);
    check("R6", "idle ones silent", obsStuff - s0, 0);

    // R7: line toggles without strobe are ignored
    v0 = obsValid; s0 = obsStuff;
    for (int i = 0; i < 5; i++) begin @(negedge clk); lineIn = ~lineIn; end
    @(negedge clk); lineIn = txLevel;
    waitCycles(2);
    check("R7", "no pulses", obsValid - v0 + obsStuff - s0, 0);
    sendFrame(8'h81, 4'h0);
    waitCycles(2);
    check("R7", "frame after toggles", lastData, 8'h81);
    sendIdle(8);

    // R8: reset in the middle of a frame
    v0 = obsValid;
    sendLogical(1'b0, 1);
    for (int i = 0; i < 4; i++) sendLogical(1'b1, 1);
    @(negedge clk); rst = 1'b1; lineIn = 1'b1;
    txLevel = 1'b1; txOnes = 0;
    waitCycles(2);
    rst = 1'b0;
    sendIdle(8);
    check("R8", "aborted by reset", obsValid - v0, 0);
    sendFrame(8'h42, 4'h0);
    waitCycles(2);
    check("R8", "frame after reset", lastData, 8'h42);
    check("R8", "one byte after reset", obsValid - v0, 1);

    // R4 R5: varied data patterns, some back to back
    v0 = obsValid; c0 = obsCrc;
    for (int i = 0; i < 16; i++) begin
      sendFrame(8'(i * 37 + 11), 4'h0);
      if (i % 3 == 0) sendIdle(7);
    end
    waitCycles(2);
    check("R4", "pattern count", obsValid - v0, 16);
    check("R5", "pattern crc clean", obsCrc - c0, 0);
    check("R4", "last pattern", lastData, 8'(15 * 37 + 11));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule